// File: doc/BRIEF.md
# SPI Flash Transaction Engine

This block is a register-programmed SPI master meant to talk to serial NOR flash. Software sets up the serial clock divider and clock mode, picks how the chip select is handled and chooses the receive sample edge. It then loads a byte count and starts a transaction through a single control/status word that also selects direction and lane width. Bytes move through one 8-entry byte FIFO. Writes to the data port feed the transmitter, and reads of the same port drain what the receiver collected.

The serial side drives SCK, an active-low chip select and up to four bidirectional data lanes, each with an output enable. A transaction shifts exactly the programmed number of bytes. The clock pauses at byte boundaries whenever the FIFO cannot supply or accept a byte. Sticky status bits report completion and FIFO readiness, and they can be routed to a level interrupt.

Word offsets: 0x00 clock setup, 0x04 select control, 0x08 sample delay, 0x0C direct-read enable (storage only), 0x10 transaction word, 0x14 byte count, 0x18 FIFO data, 0x20 FIFO level, 0x28 status, 0x2C status enable.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset, offset 0x00 reads 0x004, 0x04 reads 0, 0x0C reads 1, 0x10 reads 0, 0x20 reads 0 and 0x28 reads 0. cs_n_o is high and sck_o is low.
- R2: Each host write to 0x18 while no receive is running appends byte [7:0] to the FIFO. Offset 0x20 bits 3:0 give the number of stored bytes, with a maximum of 8, and a write when full is dropped. Writing the value 0 to 0x20 empties the FIFO.
- R3: Offset 0x00 holds the divider in bits 10:0, CPHA in bit 12 and CPOL in bit 13. Each SCK half period lasts divider+1 clock cycles, and SCK rests at the CPOL level between bytes and when idle.
- R4: Writing 0x10 with bit 15 set and bit 0 clear transmits FIFO bytes MSB first. Data changes on the launch edge and is stable on the sample edge: the leading edge when CPHA=0, the trailing edge when CPHA=1. Bit 15 reads 1 while busy.
- R5: Bits 5:4 of 0x10 set the lane count: 00 uses one lane (io 0), 01 uses lanes 1:0, 10 uses lanes 3:0, and 11 acts as 00. The lowest lane carries the least significant bit of each group, and io_oe_o enables exactly those lanes during a transmit.
- R6: With bit 0 of 0x10 set, the engine receives. Single-lane receive samples io_in_i[1] and drives only lane 0 as output. Multi-lane receive samples lanes 1:0 or 3:0 and drives none. Each received byte is appended to the FIFO, and host reads of 0x18 pop it.
- R7: With bit 14 of 0x08 clear, receive samples on the sample edge. With it set, receive samples at the end of the bit period, the opposite edge, and the data is unchanged.
- R8: A transmit holds SCK idle while the FIFO is empty and bytes remain. A receive holds SCK idle while the FIFO is full. No byte is lost or repeated.
- R9: After exactly the count in 0x14 bytes, busy clears and status bit 0 sets. A count of 0 finishes without any SCK edge.
- R10: Status bit 2 sets while the last transaction was a receive and the FIFO is not empty. Status bit 3 sets while a transmit is busy and the FIFO is not full. A status bit written 0 is cleared and one written 1 is kept. irq_o is high when any status bit and its enable bit at 0x2C are both set.
- R11: At 0x04, value 2 forces cs_n_o low, value 3 forces it high, and bit 1 clear leaves cs_n_o low exactly while a transaction is busy.
- R12: While busy, writes to 0x10 have no effect, and its fields read back as written at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Enabled status pending |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| io_out_o | output | 4 | Data lane outputs |
| io_oe_o | output | 4 | Data lane output enables |
| io_in_i | input | 4 | Data lane inputs |

## Verification
The assertions assume the host never pushes into the FIFO while a receive is running. They also assume the FIFO is flushed only while the engine is idle, so the receiver can only push when the level is below 8. The bench keeps to this: every data-port write and every flush is issued before a transaction starts or after it finishes. Clock mode, divider and sample delay are changed only while idle with chip select high, so no stray serial edge reaches the bench's flash model.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam logic [5:0] OFF_CLK   = 6'h00;
    localparam logic [5:0] OFF_SEL   = 6'h04;
    localparam logic [5:0] OFF_DLY   = 6'h08;
    localparam logic [5:0] OFF_DREN  = 6'h0C;
    localparam logic [5:0] OFF_TXN   = 6'h10;
    localparam logic [5:0] OFF_CNT   = 6'h14;
    localparam logic [5:0] OFF_DATA  = 6'h18;
    localparam logic [5:0] OFF_LVL   = 6'h20;
    localparam logic [5:0] OFF_STAT  = 6'h28;
    localparam logic [5:0] OFF_IEN   = 6'h2C;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOAD,
        SH_HALF0,
        SH_HALF1
    } sh_state_e;

    // lane-width code to number of lanes
    function automatic logic [2:0] lanes_of(input logic [1:0] code);
        case (code)
            2'b01:   return 3'd2;
            2'b10:   return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // index of the final bit group in a byte
    function automatic logic [2:0] last_group(input logic [2:0] lanes);
        case (lanes)
            3'd4:    return 3'd1;
            3'd2:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    input  logic          flush_i,
    output logic [DW-1:0] head_o,
    output logic [LW-1:0] level_o,
    output logic          empty_o,
    output logic          full_o
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] level;
    } fifo_t;

    fifo_t         q, d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    assign empty_o = (q.level == '0);
    assign full_o  = (q.level == LW'(DEPTH));
    assign level_o = q.level;
    assign head_o  = mem_q[q.rp];
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (flush_i) begin
            d = '0;
        end else begin
            if (do_push) d.wp = bump(q.wp);
            if (do_pop)  d.rp = bump(q.rp);
            case ({do_push, do_pop})
                2'b10:   d.level = q.level + 1'b1;
                2'b01:   d.level = q.level - 1'b1;
                default: d.level = q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wp] <= push_data_i;
    end

    // R2: a push into a full FIFO leaves the level unchanged
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !flush_i) |=> (level_o == LW'(DEPTH)));

    // R2: flush empties the FIFO on the next cycle
    p_flush_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
    import sfe_pkg::*;
#(
    parameter int DIV_W = 11,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic             neg_i,
    input  logic             rx_i,
    input  logic [1:0]       width_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             fifo_empty_i,
    input  logic             fifo_full_i,
    input  logic [7:0]       fifo_head_i,
    output logic             fifo_pop_o,
    output logic             fifo_push_o,
    output logic [7:0]       fifo_wdata_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             sck_o,
    output logic [3:0]       io_out_o,
    output logic [3:0]       io_oe_o,
    input  logic [3:0]       io_in_i
);

    typedef struct packed {
        sh_state_e        st;
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic             neg;
        logic             rx;
        logic [2:0]       lanes;
        logic [DIV_W-1:0] cnt;
        logic [CNT_W-1:0] rem;
        logic [7:0]       sr;
        logic [2:0]       grp;
    } sh_t;

    sh_t        q, d;
    logic [7:0] samp;
    logic [7:0] byte_v;
    logic       active;

    always_comb begin
        case (q.lanes)
            3'd4:    samp = {q.sr[3:0], io_in_i[3:0]};
            3'd2:    samp = {q.sr[5:0], io_in_i[1:0]};
            default: samp = {q.sr[6:0], io_in_i[1]};
        endcase
    end

    always_comb begin
        d            = q;
        fifo_pop_o   = 1'b0;
        fifo_push_o  = 1'b0;
        done_o       = 1'b0;
        byte_v       = (q.rx && q.neg) ? samp : q.sr;
        fifo_wdata_o = byte_v;
        case (q.st)
            SH_IDLE: begin
                if (start_i) begin
                    d.st    = SH_LOAD;
                    d.div   = div_i;
                    d.cpol  = cpol_i;
                    d.cpha  = cpha_i;
                    d.neg   = neg_i;
                    d.rx    = rx_i;
                    d.lanes = lanes_of(width_i);
                    d.rem   = count_i;
                    d.cnt   = '0;
                    d.grp   = '0;
                end
            end
            SH_LOAD: begin
                if (q.rem == '0) begin
                    done_o = 1'b1;
                    d.st   = SH_IDLE;
                end else if (!q.rx) begin
                    if (!fifo_empty_i) begin
                        fifo_pop_o = 1'b1;
                        d.sr       = fifo_head_i;
                        d.grp      = '0;
                        d.cnt      = '0;
                        d.st       = SH_HALF0;
                    end
                end else if (!fifo_full_i) begin
                    d.sr  = '0;
                    d.grp = '0;
                    d.cnt = '0;
                    d.st  = SH_HALF0;
                end
            end
            SH_HALF0: begin
                if (q.cnt == q.div) begin
                    d.cnt = '0;
                    d.st  = SH_HALF1;
                    if (q.rx && !q.neg) d.sr = samp;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SH_HALF1: begin
                if (q.cnt == q.div) begin
                    d.cnt = '0;
                    d.sr  = q.rx ? byte_v : (q.sr << q.lanes);
                    if (q.grp == last_group(q.lanes)) begin
                        d.st = SH_LOAD;
                        d.rem = q.rem - 1'b1;
                        fifo_push_o = q.rx;
                    end else begin
                        d.grp = q.grp + 1'b1;
                        d.st  = SH_HALF0;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SH_IDLE, default: '0};
        else        q <= d;
    end

    assign busy_o = (q.st != SH_IDLE);
    assign active = (q.st == SH_HALF0) || (q.st == SH_HALF1);

    always_comb begin
        if (q.st == SH_IDLE)  sck_o = cpol_i;
        else if (!active)     sck_o = q.cpol;
        else                  sck_o = q.cpol ^ q.cpha ^ (q.st == SH_HALF1);
    end

    always_comb begin
        io_out_o = 4'b0000;
        io_oe_o  = 4'b0000;
        if (busy_o) begin
            if (q.rx) begin
                io_oe_o = (q.lanes == 3'd1) ? 4'b0001 : 4'b0000;
            end else begin
                case (q.lanes)
                    3'd4: begin io_out_o = q.sr[7:4];          io_oe_o = 4'b1111; end
                    3'd2: begin io_out_o = {2'b00, q.sr[7:6]}; io_oe_o = 4'b0011; end
                    default: begin io_out_o = {3'b000, q.sr[7]}; io_oe_o = 4'b0001; end
                endcase
            end
        end
    end

    // R9: done is followed by the idle state
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R4: a start from idle makes the engine busy
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R8: transmit starved of data keeps SCK still
    p_tx_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SH_LOAD && !q.rx && fifo_empty_i && q.rem != '0) |=> $stable(sck_o));

    // R8: the receiver never pushes into a full FIFO
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push_o |-> !fifo_full_i);

endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
    import sfe_pkg::*;
#(
    parameter int DIV_W      = 11,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel_i,
    input  logic        bus_wr_i,
    input  logic [5:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o,
    output logic        sck_o,
    output logic        cs_n_o,
    output logic [3:0]  io_out_o,
    output logic [3:0]  io_oe_o,
    input  logic [3:0]  io_in_i
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpha;
        logic             cpol;
        logic [1:0]       sel;
        logic             neg;
        logic             dren;
        logic             rx;
        logic             tx;
        logic             fast;
        logic [1:0]       width;
        logic [CNT_W-1:0] count;
        logic [2:0]       stat;   // {space, rxdata, done}
        logic [2:0]       ien;
        logic             last_rx;
    } regs_t;

    regs_t      q, d;
    logic       wr_hit, rd_hit, start;
    logic       host_push, host_pop, flush;
    logic       sh_pop, sh_push, sh_busy, sh_done;
    logic [7:0] sh_wdata, head;
    logic [LW-1:0] level;
    logic       empty, full;
    logic [2:0] stat_v;

    assign wr_hit    = bus_sel_i && bus_wr_i;
    assign rd_hit    = bus_sel_i && !bus_wr_i;
    assign start     = wr_hit && bus_addr_i == OFF_TXN && bus_wdata_i[15] && !sh_busy;
    assign host_push = wr_hit && bus_addr_i == OFF_DATA && !(sh_busy && q.last_rx);
    assign host_pop  = rd_hit && bus_addr_i == OFF_DATA && !(sh_busy && !q.last_rx);
    assign flush     = wr_hit && bus_addr_i == OFF_LVL && bus_wdata_i == 32'd0;

    sfe_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (sh_push || host_push),
        .push_data_i (sh_push ? sh_wdata : bus_wdata_i[7:0]),
        .pop_i       (sh_pop || host_pop),
        .flush_i     (flush),
        .head_o      (head),
        .level_o     (level),
        .empty_o     (empty),
        .full_o      (full)
    );

    sfe_shifter #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .div_i        (q.div),
        .cpol_i       (q.cpol),
        .cpha_i       (q.cpha),
        .neg_i        (q.neg),
        .rx_i         (bus_wdata_i[0]),
        .width_i      (bus_wdata_i[5:4]),
        .count_i      (q.count),
        .fifo_empty_i (empty),
        .fifo_full_i  (full),
        .fifo_head_i  (head),
        .fifo_pop_o   (sh_pop),
        .fifo_push_o  (sh_push),
        .fifo_wdata_o (sh_wdata),
        .busy_o       (sh_busy),
        .done_o       (sh_done),
        .sck_o        (sck_o),
        .io_out_o     (io_out_o),
        .io_oe_o      (io_oe_o),
        .io_in_i      (io_in_i)
    );

    always_comb begin
        d = q;
        if (wr_hit) begin
            case (bus_addr_i)
                OFF_CLK: begin
                    d.div  = bus_wdata_i[DIV_W-1:0];
                    d.cpha = bus_wdata_i[12];
                    d.cpol = bus_wdata_i[13];
                end
                OFF_SEL:  d.sel  = bus_wdata_i[1:0];
                OFF_DLY:  d.neg  = bus_wdata_i[14];
                OFF_DREN: d.dren = bus_wdata_i[0];
                OFF_TXN: begin
                    if (!sh_busy) begin
                        d.rx    = bus_wdata_i[0];
                        d.tx    = bus_wdata_i[1];
                        d.fast  = bus_wdata_i[3];
                        d.width = bus_wdata_i[5:4];
                    end
                end
                OFF_CNT:  d.count = bus_wdata_i[CNT_W-1:0];
                OFF_STAT: d.stat  = q.stat & {bus_wdata_i[3], bus_wdata_i[2], bus_wdata_i[0]};
                OFF_IEN:  d.ien   = {bus_wdata_i[3], bus_wdata_i[2], bus_wdata_i[0]};
                default: ;
            endcase
        end
        if (start) d.last_rx = bus_wdata_i[0];
        if (sh_done) d.stat[0] = 1'b1;
        if (q.last_rx && !empty) d.stat[1] = 1'b1;
        if (sh_busy && !q.last_rx && !full) d.stat[2] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.div  <= DIV_W'(4);
            q.dren <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign stat_v = q.stat;
    assign irq_o  = |(q.stat & q.ien);
    assign cs_n_o = q.sel[1] ? q.sel[0] : !sh_busy;

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFF_CLK:  bus_rdata_o = {18'd0, q.cpol, q.cpha, 1'b0, q.div};
            OFF_SEL:  bus_rdata_o = {30'd0, q.sel};
            OFF_DLY:  bus_rdata_o = {17'd0, q.neg, 14'd0};
            OFF_DREN: bus_rdata_o = {31'd0, q.dren};
            OFF_TXN:  bus_rdata_o = {16'd0, sh_busy, 9'd0, q.width, q.fast, 1'b0, q.tx, q.rx};
            OFF_CNT:  bus_rdata_o = 32'(q.count);
            OFF_DATA: bus_rdata_o = {24'd0, head};
            OFF_LVL:  bus_rdata_o = 32'(level);
            OFF_STAT: bus_rdata_o = {28'd0, stat_v[2], stat_v[1], 1'b0, stat_v[0]};
            OFF_IEN:  bus_rdata_o = {28'd0, q.ien[2], q.ien[1], 1'b0, q.ien[0]};
            default:  bus_rdata_o = '0;
        endcase
    end

    // R9: completion of the engine sets the sticky done bit
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> q.stat[0]);

    // R11: with hardware select, the select line rises once the engine goes idle
    p_cs_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sh_busy) && !q.sel[1]) |-> cs_n_o);

    // R12: transaction fields hold while busy
    p_txn_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && $past(sh_busy)) |-> $stable({q.rx, q.tx, q.width}));

endmodule

// File: tb/spi_flash_engine_tb.sv
`timescale 1ns/1ps
module spi_flash_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sck, cs_n;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in;

    always #2.5 clk = ~clk;

    spi_flash_engine u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq), .sck_o(sck), .cs_n_o(cs_n), .io_out_o(io_out),
        .io_oe_o(io_oe), .io_in_i(io_in)
    );

    int total = 0, bad = 0;
    logic m_cpol = 1'b0, m_cpha = 1'b0;
    int   m_lanes = 1;
    logic mon_en = 1'b0, slv_en = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] mon_sr = '0;
    int   mon_bits = 0, mon_cnt = 0;
    logic [7:0] rx_mem [16];
    int   slv_idx = 0;
    logic done_flag = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic br(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 4000 && v[0] == 1'b0; i++) br(6'h28, v);
        chk(tag, {31'd0, v[0]}, 32'd1);
    endtask

    // scoreboard monitor: sample on the sample edge of the current mode
    wire s_edge = sck ^ m_cpol ^ m_cpha;
    always @(posedge s_edge) begin
        if (mon_en && !cs_n) begin
            case (m_lanes)
                4: mon_sr = {mon_sr[3:0], io_out[3:0]};
                2: mon_sr = {mon_sr[5:0], io_out[1:0]};
                default: mon_sr = {mon_sr[6:0], io_out[0]};
            endcase
            mon_bits += m_lanes;
            if (mon_bits == 8) begin
                mon_bits = 0;
                mon_cnt++;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R4 unexpected byte act=%h exp=none", mon_sr);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (mon_sr !== e) begin
                        bad++;
                        $display("FAIL R4/R5 tx byte act=%h exp=%h", mon_sr, e);
                    end
                end
            end
        end
    end

    // flash model: advance one bit group on each launch edge
    always @(negedge s_edge) if (slv_en && !cs_n) slv_idx++;

    always_comb begin
        int gpb, bi, pos;
        logic [7:0] b;
        gpb = 8 / m_lanes;
        bi  = (slv_idx / gpb) % 16;
        pos = slv_idx % gpb;
        b   = rx_mem[bi] >> (8 - m_lanes * (pos + 1));
        case (m_lanes)
            4: io_in = b[3:0];
            2: io_in = {2'b00, b[1:0]};
            default: io_in = {2'b00, b[0], 1'b0};
        endcase
    end

    task automatic tx_run(input string tag, input int n, input logic [31:0] txn);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'(8'h3C * i + 8'hA5 + n);
            exp_q.push_back(v);
            bw(6'h18, {24'd0, v});
        end
        bw(6'h14, n);
        mon_cnt = 0; mon_bits = 0; mon_en = 1'b1;
        bw(6'h10, txn);
        wait_done(tag);
        mon_en = 1'b0;
        chk({tag, " count"}, mon_cnt, n);
        chk({tag, " sb empty"}, exp_q.size(), 0);
        bw(6'h28, 0);
    endtask

    task automatic rx_read(input string tag, input int first, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] v;
            br(6'h18, v);
            chk(tag, {24'd0, v[7:0]}, {24'd0, rx_mem[first + i]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        realtime t0, t1;
        for (int i = 0; i < 16; i++) rx_mem[i] = 8'(8'h5A ^ (i * 8'h13) ^ (i << 5));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        br(6'h00, v); chk("R1 clk reg", v, 32'h004);
        br(6'h04, v); chk("R1 sel reg", v, 0);
        br(6'h0C, v); chk("R1 dren", v, 1);
        br(6'h10, v); chk("R1 txn", v, 0);
        br(6'h20, v); chk("R1 level", v, 0);
        br(6'h28, v); chk("R1 status", v, 0);
        chk("R1 pins", {30'd0, cs_n, sck}, 32'b10);

        // R2 FIFO level, overflow drop, flush
        for (int i = 0; i < 10; i++) bw(6'h18, i);
        br(6'h20, v); chk("R2 level full", v, 8);
        bw(6'h20, 0);
        br(6'h20, v); chk("R2 flush", v, 0);

        // R4 single-lane transmit, mode 0, with R3 half period at divider 2
        bw(6'h00, 32'h2);
        fork
            begin
                @(posedge sck); t0 = $realtime;
                @(negedge sck); t1 = $realtime;
            end
            tx_run("R4 1-lane", 3, 32'h8002);
        join
        chk("R3 half period", int'((t1 - t0) / 5.0), 3);
        bw(6'h00, 32'h4);

        // R5 two and four lanes
        m_lanes = 2; tx_run("R5 2-lane", 4, 32'h8012);
        m_lanes = 4;
        for (int i = 0; i < 2; i++) begin exp_q.push_back(8'hC3 + 8'(i)); bw(6'h18, 8'hC3 + i); end
        bw(6'h14, 2); mon_cnt = 0; mon_bits = 0; mon_en = 1'b1;
        bw(6'h10, 32'h8022);
        chk("R5 oe 4-lane", io_oe, 4'hF);
        wait_done("R5 4-lane done");
        mon_en = 1'b0; chk("R5 4-lane bytes", mon_cnt, 2); bw(6'h28, 0);
        m_lanes = 3; m_lanes = 1; tx_run("R5 code 11", 2, 32'h8032);

        // R3 CPOL idle, R4 CPHA=1 transmit (mode 3)
        bw(6'h00, 32'h3004); m_cpol = 1'b1; m_cpha = 1'b1;
        @(negedge clk); chk("R3 idle cpol", sck, 1);
        tx_run("R4 mode3", 2, 32'h8002);
        bw(6'h00, 32'h4); m_cpol = 1'b0; m_cpha = 1'b0;

        // R8 transmit stall, R10 space bit, R11 hw select, R12 ignored write
        exp_q.push_back(8'h11); bw(6'h18, 8'h11);
        exp_q.push_back(8'h22); bw(6'h18, 8'h22);
        bw(6'h14, 4); mon_cnt = 0; mon_bits = 0; mon_en = 1'b1;
        bw(6'h10, 32'h8002);
        repeat (300) @(posedge clk);
        br(6'h28, v); chk("R8 not done while starved", {31'd0, v[0]}, 0);
        chk("R10 space bit", {31'd0, v[3]}, 1);
        chk("R8 bytes sent before stall", mon_cnt, 2);
        chk("R11 cs low while busy", cs_n, 0);
        bw(6'h10, 32'h8021);
        br(6'h10, v); chk("R12 txn unchanged", v, 32'h8002);
        exp_q.push_back(8'h33); bw(6'h18, 8'h33);
        exp_q.push_back(8'h44); bw(6'h18, 8'h44);
        wait_done("R8 resume done"); mon_en = 1'b0;
        chk("R8 all bytes", mon_cnt, 4);
        @(negedge clk); chk("R11 cs high idle", cs_n, 1);

        // R10 interrupt routing and clearing
        bw(6'h2C, 32'h1);
        @(negedge clk); chk("R10 irq", irq, 1);
        bw(6'h28, 32'h0);
        br(6'h28, v); chk("R10 cleared", v, 0);
        @(negedge clk); chk("R10 irq low", irq, 0);
        bw(6'h2C, 32'h0);

        // R9 count zero
        bw(6'h14, 0); mon_en = 1'b1; mon_cnt = 0;
        bw(6'h10, 32'h8002);
        wait_done("R9 zero count"); mon_en = 1'b0;
        chk("R9 zero count no bytes", mon_cnt, 0);
        bw(6'h28, 0);

        // R6 single-lane receive with R8 full stall
        slv_idx = 0; slv_en = 1'b1; m_lanes = 1;
        bw(6'h14, 10); bw(6'h10, 32'h8001);
        chk("R6 oe 1-lane rx", io_oe, 4'h1);
        v = 0;
        for (int i = 0; i < 2000 && v != 8; i++) br(6'h20, v);
        repeat (200) @(posedge clk);
        br(6'h20, v); chk("R8 rx level held", v, 8);
        br(6'h10, v); chk("R8 rx busy", {31'd0, v[15]}, 1);
        br(6'h28, v); chk("R10 rxdata bit", {31'd0, v[2]}, 1);
        rx_read("R6 rx byte", 0, 8);
        wait_done("R6 rx done");
        rx_read("R6 rx tail", 8, 2);
        slv_en = 1'b0; bw(6'h28, 0);

        // R7 four-lane receive at divider 1 with opposite-edge sampling
        bw(6'h00, 32'h1); bw(6'h08, 32'h4000);
        slv_idx = 0; slv_en = 1'b1; m_lanes = 4;
        bw(6'h14, 5); bw(6'h10, 32'h8021);
        chk("R6 oe 4-lane rx", io_oe, 4'h0);
        wait_done("R7 rx done");
        rx_read("R7 neg-sample byte", 0, 5);
        slv_en = 1'b0; bw(6'h28, 0);

        // R7 two-lane receive on the normal edge
        bw(6'h08, 0); slv_idx = 0; slv_en = 1'b1; m_lanes = 2;
        bw(6'h14, 3); bw(6'h10, 32'h8011);
        wait_done("R7 2-lane rx done");
        rx_read("R7 2-lane byte", 0, 3);
        slv_en = 1'b0; bw(6'h28, 0);
        bw(6'h00, 32'h4);

        // R11 manual select
        bw(6'h04, 2); @(negedge clk); chk("R11 manual low", cs_n, 0);
        bw(6'h04, 3); @(negedge clk); chk("R11 manual high", cs_n, 1);
        bw(6'h04, 0); @(negedge clk); chk("R11 hardware idle", cs_n, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule